// File: doc/BRIEF.md
# Memory Traffic Generator and Read Checker

This block exercises a memory controller through its user command port. It sits idle after reset. Once the controller reports that calibration is done, it runs passes over a power-of-two window of addresses. A pass first writes every location in ascending order. It then reads every location back in the same order. The pass number is mixed into the data pattern, so stale contents from an earlier pass are detected.

Each write word is computed from its address and the pass number. The block keeps the address and pass of every outstanding read in a small in-order queue. When a word returns, it rebuilds the expected pattern and compares it with the returned word. Mismatches are reported in two ways: a one-cycle pulse for each bad word, and a sticky flag that only reset clears. The block honours the full flags of the controller's command queue and write data queue. Before it switches from writing to reading, it waits until both queues report empty.

Top module: `mem_traffic_gen`

## Requirements
- R1: While calibration has never been reported done since reset, cmd_en_o and wr_en_o stay low.
- R2: The command code is 2'b00 for write and 2'b01 for read. While cmd_en_o is low, cmd_o shows no-operation (2'b10).
- R3: No command is issued in a cycle where cmd_fifo_full_i is high. No write is issued in a cycle where wdata_fifo_full_i is high.
- R4: A write command comes with wr_en_o high in the same cycle and wr_mask_o all zero (a mask bit of 1 would block a byte). A read command has wr_en_o low.
- R5: Each pass issues writes to addresses 0 up to 2^ADDR_W-1 in ascending order, then reads in the same order. bank_o equals the low BANK_W bits of addr_o.
- R6: Write data is the 16-bit value addr XOR (pass*16'h9E37), truncated to 16 bits and replicated across the data word. The pass number starts at 0 after reset and increments after each pass.
- R7: After the last write of a pass, no read is issued until cmd_fifo_empty_i and wdata_fifo_empty_i are both high.
- R8: At most RDQ_DEPTH reads are outstanding at any time. The writes of the next pass start only after every read of the current pass has returned.
- R9: Returned data is examined only when rd_valid_i is high. A word that differs from the expected pattern, or a valid word arriving with no read outstanding, raises err_pulse_o for exactly one cycle, one cycle after the word. Each bad word gives its own pulse.
- R10: err_sticky_o rises together with the first err_pulse_o and stays high until rst_ni is asserted.
- R11: While in reset, cmd_en_o, wr_en_o, err_pulse_o and err_sticky_o are low and cmd_o is no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| calib_done_i | input | 1 | Controller calibration finished |
| cmd_fifo_full_i | input | 1 | Controller command queue full |
| cmd_fifo_empty_i | input | 1 | Controller command queue empty |
| wdata_fifo_full_i | input | 1 | Controller write data queue full |
| wdata_fifo_empty_i | input | 1 | Controller write data queue empty |
| rd_valid_i | input | 1 | Returned read word valid |
| rd_data_i | input | DATA_W | Returned read word |
| cmd_en_o | output | 1 | Command strobe |
| cmd_o | output | 2 | Command code |
| addr_o | output | ADDR_W | Command address |
| bank_o | output | BANK_W | Command bank |
| wr_en_o | output | 1 | Write data strobe |
| wr_data_o | output | DATA_W | Write data |
| wr_mask_o | output | DATA_W/8 | Byte mask, 1 blocks a byte |
| err_sticky_o | output | 1 | Mismatch seen since reset |
| err_pulse_o | output | 1 | One pulse per mismatching word |

## Verification
The assertions assume two things about the controller. It raises rd_valid_i only for reads it has accepted. It returns those reads in issue order. Only the deliberate stray-word tests step outside this, and those are the cases where an error is the expected result. The stimulus stub returns reads strictly in order after a fixed latency that is longer than the read queue depth, so the outstanding-read limit is reached. It drives the full flags with periodic patterns and holds the empty flags low for a while after each write phase.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b01,
    CMD_NOP   = 2'b10
  } mtg_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WDRAIN,
    ST_READ,
    ST_RDRAIN
  } mtg_state_e;

  localparam logic [15:0] PASS_MIX = 16'h9E37;
endpackage

// File: rtl/mtg_pattern_gen.sv
module mtg_pattern_gen #(
  parameter int ADDR_W = 5,
  parameter int PASS_W = 4,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PASS_W-1:0] pass_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int REPS = DATA_W / 16;

  logic [15:0] seed;
  logic [15:0] mix;

  assign mix  = 16'(pass_i) * mtg_pkg::PASS_MIX;
  assign seed = 16'(addr_i) ^ mix;

  for (genvar g = 0; g < REPS; g++) begin : g_rep
    assign data_o[g*16 +: 16] = seed;
  end
endmodule

// File: rtl/mtg_sequencer.sv
module mtg_sequencer #(
  parameter int ADDR_W = 5,
  parameter int PASS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_done_i,
  input  logic              cmd_full_i,
  input  logic              cmd_empty_i,
  input  logic              wd_full_i,
  input  logic              wd_empty_i,
  input  logic              rdq_full_i,
  input  logic              rdq_empty_i,
  output logic              wr_fire_o,
  output logic              rd_fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PASS_W-1:0] pass_o
);
  import mtg_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  mtg_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PASS_W-1:0] pass_q;

  assign wr_fire_o = (state_q == ST_WRITE) && !cmd_full_i && !wd_full_i;
  assign rd_fire_o = (state_q == ST_READ) && !cmd_full_i && !rdq_full_i;
  assign addr_o    = addr_q;
  assign pass_o    = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pass_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (calib_done_i) state_q <= ST_WRITE;
        ST_WRITE: if (wr_fire_o) begin
          if (addr_q == LAST_ADDR) begin
            addr_q  <= '0;
            state_q <= ST_WDRAIN;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        // writes must land before read-back starts
        ST_WDRAIN: if (cmd_empty_i && wd_empty_i) state_q <= ST_READ;
        ST_READ: if (rd_fire_o) begin
          if (addr_q == LAST_ADDR) begin
            addr_q  <= '0;
            state_q <= ST_RDRAIN;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_RDRAIN: if (rdq_empty_i) begin
          pass_q  <= pass_q + 1'b1;
          state_q <= ST_WRITE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mtg_read_tracker.sv
module mtg_read_tracker #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slots_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign head_o  = slots_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) slots_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/mtg_compare.sv
module mtg_compare #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic              exp_avail_i,
  output logic              err_pulse_o,
  output logic              err_sticky_o
);
  logic bad;

  // a word with no read outstanding counts as a mismatch
  assign bad = rd_valid_i && (!exp_avail_i || (rd_data_i != exp_data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pulse_o  <= 1'b0;
      err_sticky_o <= 1'b0;
    end else begin
      err_pulse_o  <= bad;
      err_sticky_o <= err_sticky_o | bad;
    end
  end
endmodule

// File: rtl/mem_traffic_gen.sv
module mem_traffic_gen #(
  parameter int ADDR_W    = 5,
  parameter int BANK_W    = 3,
  parameter int DATA_W    = 32,
  parameter int PASS_W    = 4,
  parameter int RDQ_DEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                calib_done_i,
  input  logic                cmd_fifo_full_i,
  input  logic                cmd_fifo_empty_i,
  input  logic                wdata_fifo_full_i,
  input  logic                wdata_fifo_empty_i,
  input  logic                rd_valid_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                cmd_en_o,
  output logic [1:0]          cmd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic                wr_en_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_mask_o,
  output logic                err_sticky_o,
  output logic                err_pulse_o
);
  import mtg_pkg::*;

  localparam int TAG_W  = PASS_W + ADDR_W;
  localparam int MASK_W = DATA_W / 8;

  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] seq_addr;
  logic [PASS_W-1:0] seq_pass;
  logic              rdq_full, rdq_empty;
  logic [TAG_W-1:0]  rdq_head;
  logic [DATA_W-1:0] wr_pattern, exp_pattern;

  mtg_sequencer #(.ADDR_W(ADDR_W), .PASS_W(PASS_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .calib_done_i (calib_done_i),
    .cmd_full_i   (cmd_fifo_full_i),
    .cmd_empty_i  (cmd_fifo_empty_i),
    .wd_full_i    (wdata_fifo_full_i),
    .wd_empty_i   (wdata_fifo_empty_i),
    .rdq_full_i   (rdq_full),
    .rdq_empty_i  (rdq_empty),
    .wr_fire_o    (wr_fire),
    .rd_fire_o    (rd_fire),
    .addr_o       (seq_addr),
    .pass_o       (seq_pass)
  );

  mtg_pattern_gen #(.ADDR_W(ADDR_W), .PASS_W(PASS_W), .DATA_W(DATA_W)) i_wr_pat (
    .addr_i (seq_addr),
    .pass_i (seq_pass),
    .data_o (wr_pattern)
  );

  mtg_read_tracker #(.DEPTH(RDQ_DEPTH), .WIDTH(TAG_W)) i_rdq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rd_fire),
    .push_data_i ({seq_pass, seq_addr}),
    .pop_i       (rd_valid_i),
    .head_o      (rdq_head),
    .empty_o     (rdq_empty),
    .full_o      (rdq_full)
  );

  mtg_pattern_gen #(.ADDR_W(ADDR_W), .PASS_W(PASS_W), .DATA_W(DATA_W)) i_exp_pat (
    .addr_i (rdq_head[ADDR_W-1:0]),
    .pass_i (rdq_head[TAG_W-1:ADDR_W]),
    .data_o (exp_pattern)
  );

  mtg_compare #(.DATA_W(DATA_W)) i_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i),
    .exp_data_i   (exp_pattern),
    .exp_avail_i  (!rdq_empty),
    .err_pulse_o  (err_pulse_o),
    .err_sticky_o (err_sticky_o)
  );

  assign cmd_en_o  = wr_fire | rd_fire;
  assign cmd_o     = wr_fire ? CMD_WRITE : (rd_fire ? CMD_READ : CMD_NOP);
  assign addr_o    = seq_addr;
  assign bank_o    = seq_addr[BANK_W-1:0];
  assign wr_en_o   = wr_fire;
  assign wr_data_o = wr_fire ? wr_pattern : '0;
  assign wr_mask_o = {MASK_W{1'b0}};
endmodule

// File: rtl/mem_traffic_gen_sva.sv
module mem_traffic_gen_sva #(
  parameter int ADDR_W    = 5,
  parameter int BANK_W    = 3,
  parameter int DATA_W    = 32,
  parameter int RDQ_DEPTH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                calib_done_i,
  input logic                cmd_fifo_full_i,
  input logic                wdata_fifo_full_i,
  input logic                rd_valid_i,
  input logic                cmd_en_o,
  input logic [1:0]          cmd_o,
  input logic                wr_en_o,
  input logic [DATA_W/8-1:0] wr_mask_o,
  input logic                err_sticky_o,
  input logic                err_pulse_o
);
  localparam int CNT_W = $clog2(RDQ_DEPTH + 2) + 1;

  logic             calib_seen_q;
  logic [CNT_W-1:0] outstanding_q;
  logic             rd_cmd;

  assign rd_cmd = cmd_en_o && (cmd_o == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      calib_seen_q  <= 1'b0;
      outstanding_q <= '0;
    end else begin
      if (calib_done_i) calib_seen_q <= 1'b1;
      if (rd_cmd && !(rd_valid_i && outstanding_q != '0)) outstanding_q <= outstanding_q + 1'b1;
      else if (!rd_cmd && rd_valid_i && outstanding_q != '0) outstanding_q <= outstanding_q - 1'b1;
    end
  end

  // R1
  idle_before_calib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !calib_seen_q |-> (!cmd_en_o && !wr_en_o));

  // R2
  cmd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> (cmd_o == 2'b00 || cmd_o == 2'b01));

  // R3
  cmd_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> !cmd_fifo_full_i);

  // R3
  wdata_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wdata_fifo_full_i);

  // R4
  write_pairing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (cmd_en_o && cmd_o == 2'b00 && wr_mask_o == '0));

  // R8
  rd_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q <= CNT_W'(RDQ_DEPTH));

  // R10
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);

  // R10
  pulse_sets_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> err_sticky_o);
endmodule

bind mem_traffic_gen mem_traffic_gen_sva #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .RDQ_DEPTH(RDQ_DEPTH)
) i_sva (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .calib_done_i      (calib_done_i),
  .cmd_fifo_full_i   (cmd_fifo_full_i),
  .wdata_fifo_full_i (wdata_fifo_full_i),
  .rd_valid_i        (rd_valid_i),
  .cmd_en_o          (cmd_en_o),
  .cmd_o             (cmd_o),
  .wr_en_o           (wr_en_o),
  .wr_mask_o         (wr_mask_o),
  .err_sticky_o      (err_sticky_o),
  .err_pulse_o       (err_pulse_o)
);

// File: tb/test_mem_traffic_gen.sv
`timescale 1ns/1ps
module test_mem_traffic_gen;
  localparam int ADDR_W = 5;
  localparam int BANK_W = 3;
  localparam int DATA_W = 32;
  localparam int PASS_W = 4;
  localparam int RDQ_DEPTH = 4;
  localparam int NLOC = 1 << ADDR_W;
  localparam int LAT = 6;
  localparam int HOLD = 12;
  localparam int ROWS = 4;
  // {cmd full period, wdata full period, corrupted read index (0 = none)}
  localparam logic [23:0] ROW_TAB [ROWS] = '{
    {8'd0, 8'd0, 8'd0},
    {8'd3, 8'd0, 8'd0},
    {8'd0, 8'd2, 8'd5},
    {8'd4, 8'd5, 8'd17}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic calib = 1'b0;
  logic cmd_full, wd_full, cmd_empty, wd_empty;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic cmd_en, wr_en, err_sticky, err_pulse;
  logic [1:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W/8-1:0] wr_mask;

  int checks = 0;
  int failures = 0;

  int cmd_stall = 0, wd_stall = 0, corrupt_idx = 0;
  logic inj_rv = 1'b0;
  logic [DATA_W-1:0] inj_data = '0;

  always #2.5 clk = ~clk;

  mem_traffic_gen #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .PASS_W(PASS_W), .RDQ_DEPTH(RDQ_DEPTH)
  ) i_mem_traffic_gen (
    .clk_i(clk), .rst_ni(rst_n), .calib_done_i(calib),
    .cmd_fifo_full_i(cmd_full), .cmd_fifo_empty_i(cmd_empty),
    .wdata_fifo_full_i(wd_full), .wdata_fifo_empty_i(wd_empty),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .cmd_en_o(cmd_en), .cmd_o(cmd), .addr_o(addr), .bank_o(bank),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_mask_o(wr_mask),
    .err_sticky_o(err_sticky), .err_pulse_o(err_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_word(input int a, input int p);
    logic [15:0] v;
    v = 16'(a) ^ 16'(16'(p) * 16'h9E37);
    return {v, v};
  endfunction

  // controller stub: in-order memory, fixed read latency
  logic [DATA_W-1:0] mem [NLOC];
  logic [LAT-1:0] pv;
  logic [DATA_W-1:0] pd [LAT];
  int cyc, rd_issued, hold_cnt, ret_cnt;

  assign rd_valid  = pv[LAT-1] | inj_rv;
  assign rd_data   = inj_rv ? inj_data : pd[LAT-1];
  assign cmd_empty = (hold_cnt == 0);
  assign wd_empty  = (hold_cnt == 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; rd_issued <= 0; hold_cnt <= 0; ret_cnt <= 0;
      pv <= '0; cmd_full <= 1'b0; wd_full <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      cmd_full <= (cmd_stall > 0) && (((cyc + 1) % cmd_stall) == 0);
      wd_full  <= (wd_stall > 0) && (((cyc + 1) % wd_stall) == 0);
      pv <= {pv[LAT-2:0], 1'b0};
      for (int i = LAT - 1; i > 0; i--) pd[i] <= pd[i-1];
      if (pv[LAT-1]) ret_cnt <= ret_cnt + 1;
      if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
      if (cmd_en && cmd == 2'b00) begin
        mem[addr] <= wr_data;
        if (int'(addr) == NLOC - 1) hold_cnt <= HOLD;
      end
      if (cmd_en && cmd == 2'b01) begin
        rd_issued <= rd_issued + 1;
        pv[0] <= 1'b1;
        pd[0] <= (rd_issued + 1 == corrupt_idx) ? (mem[addr] ^ 32'h1) : mem[addr];
      end
    end
  end

  // monitor: independent model of the command stream and error outputs
  bit mon_calib_seen, mon_phase_rd, pred_pulse, exp_sticky;
  int mon_addr, mon_pass, pulse_cnt;
  logic [15:0] rq [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_calib_seen = 0; mon_phase_rd = 0; mon_addr = 0; mon_pass = 0;
      pred_pulse = 0; exp_sticky = 0; rq.delete();
    end else begin
      exp_sticky = exp_sticky | pred_pulse;
      chk(err_pulse == pred_pulse, "R9", "err_pulse", err_pulse, pred_pulse);
      chk(err_sticky == exp_sticky, "R10", "err_sticky", err_sticky, exp_sticky);
      if (err_pulse) pulse_cnt++;
      if (!mon_calib_seen) chk(!cmd_en && !wr_en, "R1", "command before calibration", cmd_en, 0);
      if (!cmd_en) chk(cmd == 2'b10 && !wr_en, "R2", "idle code", cmd, 2'b10);
      if (rd_valid) begin
        if (rq.size() == 0) pred_pulse = 1;
        else begin
          pred_pulse = (rd_data != exp_word(rq[0][7:0], rq[0][15:8]));
          void'(rq.pop_front());
        end
      end else pred_pulse = 0;
      if (cmd_en) begin
        chk(!cmd_full, "R3", "command while full", cmd_full, 0);
        chk(int'(addr) == mon_addr, "R5", "address order", addr, mon_addr);
        chk(bank == addr[BANK_W-1:0], "R5", "bank bits", bank, addr[BANK_W-1:0]);
        if (!mon_phase_rd) begin
          chk(cmd == 2'b00, "R2", "write code", cmd, 2'b00);
          chk(!wd_full, "R3", "write while data full", wd_full, 0);
          chk(wr_en && wr_mask == '0, "R4", "write strobe/mask", {wr_en, wr_mask}, 5'h10);
          chk(wr_data == exp_word(mon_addr, mon_pass), "R6", "write data", wr_data,
              exp_word(mon_addr, mon_pass));
          chk(rq.size() == 0, "R8", "write with reads pending", rq.size(), 0);
        end else begin
          chk(cmd == 2'b01, "R2", "read code", cmd, 2'b01);
          chk(!wr_en, "R4", "read with write strobe", wr_en, 0);
          chk(hold_cnt == 0, "R7", "read before queues drained", hold_cnt, 0);
          rq.push_back({8'(mon_pass), 8'(mon_addr)});
          chk(rq.size() <= RDQ_DEPTH, "R8", "outstanding reads", rq.size(), RDQ_DEPTH);
        end
        mon_addr++;
        if (mon_addr == NLOC) begin
          mon_addr = 0;
          if (mon_phase_rd) mon_pass = (mon_pass + 1) % (1 << PASS_W);
          mon_phase_rd = !mon_phase_rd;
        end
      end
      if (calib) mon_calib_seen = 1;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    calib = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!cmd_en && !wr_en && cmd == 2'b10, "R11", "reset command outputs", {cmd_en, wr_en, cmd}, 4'b0010);
    chk(!err_pulse && !err_sticky, "R11", "reset error outputs", {err_pulse, err_sticky}, 0);
    rst_n = 1'b1;
  endtask

  task automatic inject(input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    inj_rv = 1'b1; inj_data = d;
    @(posedge clk); #1;
    inj_rv = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      cmd_stall = int'(ROW_TAB[r][23:16]);
      wd_stall = int'(ROW_TAB[r][15:8]);
      corrupt_idx = int'(ROW_TAB[r][7:0]);
      do_reset();
      pulse_cnt = 0;
      repeat (10) @(posedge clk);
      #1 calib = 1'b1;
      while (ret_cnt < 2 * NLOC) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
      chk(err_sticky == (corrupt_idx != 0), "R10", "row sticky", err_sticky, corrupt_idx != 0);
      chk(pulse_cnt == ((corrupt_idx != 0) ? 1 : 0), "R9", "row pulse count", pulse_cnt,
          (corrupt_idx != 0) ? 1 : 0);
    end

    // R1: calibration held off for a long time with free queues
    cmd_stall = 0; wd_stall = 0; corrupt_idx = 0;
    do_reset();
    repeat (40) begin
      @(posedge clk); #1;
      chk(!cmd_en, "R1", "idle without calibration", cmd_en, 0);
    end

    // R9/R10: stray word, sticky holds, reset clears
    pulse_cnt = 0;
    inject(32'hDEAD_BEEF);
    chk(err_pulse && err_sticky, "R9", "stray word pulse", {err_pulse, err_sticky}, 2'b11);
    repeat (20) @(posedge clk);
    #1;
    chk(err_sticky && !err_pulse, "R10", "sticky hold", {err_sticky, err_pulse}, 2'b10);
    do_reset();
    #1;
    chk(!err_sticky, "R10", "sticky cleared by reset", err_sticky, 0);

    // R9: back-to-back bad words give one pulse each
    pulse_cnt = 0;
    @(posedge clk); #1;
    inj_rv = 1'b1; inj_data = 32'h1;
    @(posedge clk); #1;
    inj_data = 32'h2;
    @(posedge clk); #1;
    inj_rv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(pulse_cnt == 2, "R9", "pulse per mismatch", pulse_cnt, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule